// File: doc/BRIEF.md
# Per-Pin Pad Configuration Controller

This block holds the configuration of a small bank of general-purpose pins and drives the pad control signals for each one. Every pin owns two registers on a simple word-addressed bus. The first is a setup register with a function-select field, a bias field, a drive-strength code and an output-enable bit. The second is a data register that holds the level driven onto the pin and the synchronised level read from it. A separate one-bit hold register drives a system power-hold line. Software clears that line by writing zero to it, and this requests a reset or power-down.

Pin bias comes from a two-bit code. A build-time option sets whether code 2 selects a bus keeper or a pull-up. The drive code selects an even current from 2 mA to 16 mA, and the block reports that current next to the raw code. Pad inputs pass through a two-stage synchroniser before software can read them. Writes carry per-byte strobes. Reads return data one cycle after the request.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every setup register reads 0x001 (bias code 1, function 0, drive code 0, output disabled). Every data register reads 0. `power_hold` is 1, every pin shows pull-down, and every pin reports 2 mA.
- R2: With the keeper option enabled (default), the bias code in setup bits [1:0] drives exactly one of these: 0 gives no bias, 1 gives `pad_pd`, 2 gives `pad_keep`, 3 gives `pad_pu`.
- R3: With the keeper option disabled, bias codes 2 and 3 both drive `pad_pu`, and `pad_keep` stays 0.
- R4: The drive code in setup bits [8:6] appears on `pad_drv`. `pad_ma` shows (code+1)*2, from 2 to 16.
- R5: Setup bit 9 drives `pad_oe`. `pad_out` carries data bit 1 only while that bit is 1, and is 0 otherwise.
- R6: The 3-bit function select sits at bits [FSEL_LSB+2:FSEL_LSB] (default bits [4:2]) and drives `pad_fsel`.
- R7: A change on `pad_in` passes through two flops. A read whose request edge is the third edge after the change returns the new level in data bit 0. Reads at the first and second edges return the old level.
- R8: Pin n's setup register is at byte offset 8n, and its data register is at 8n+4. Data bit 1 is writable and reads back. Data bit 0 is read-only.
- R9: A write changes only the bytes whose `wstrb` bit is set. Unimplemented bits read as 0.
- R10: Reading an unmapped address returns 0, and writing one changes no register.
- R11: A write of bit 0 = 0 to offset 0x820 with `wstrb[0]` set drives `power_hold` to 0 on the next edge. Writing 1 sets it back to 1. A write with `wstrb[0]` clear leaves it unchanged.
- R12: `rdata` holds the addressed register on the clock edge after the edge that samples `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| wr_en | input | 1 | Write request |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write strobes |
| rd_en | input | 1 | Read request |
| rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output level, gated by enable |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pull-up select |
| pad_pd | output | NUM_PINS | Pull-down select |
| pad_keep | output | NUM_PINS | Keeper select |
| pad_drv | output | 3*NUM_PINS | Drive code per pin |
| pad_ma | output | 5*NUM_PINS | Drive strength in mA per pin |
| pad_fsel | output | 3*NUM_PINS | Function select per pin |
| power_hold | output | 1 | Power-hold line, 1 while held |

## Verification
Register writes take effect on the edge that samples `wr_en`. All pad outputs are combinational from those registers, so the bench checks them on the following falling edge. Read data is registered, so each read request is driven at a falling edge and `rdata` is sampled one time unit after the next rising edge. Pad inputs need two further edges. The bench therefore changes `pad_in` at a falling edge and issues three back-to-back reads, and expects the old level, the old level again, and then the new level. The power-hold line is checked on the falling edge after the write that clears it.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
   localparam int REG_W = 32;

   // bias code values
   typedef enum logic [1:0] {
      BIAS_NONE = 2'd0,
      BIAS_DOWN = 2'd1,
      BIAS_KEEP = 2'd2,
      BIAS_UP   = 2'd3
   } bias_e;

   function automatic logic [REG_W-1:0] field_mask(input int lsb, input int width);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction

   function automatic logic [4:0] drive_to_ma(input logic [2:0] code);
      return ({2'b00, code} + 5'd1) << 1;
   endfunction
endpackage

// File: rtl/gpad_sync.sv
module gpad_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpad_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end
   assign q = chain[STAGES-1];

   // checker-only: counts cycles since reset so the history window is valid
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
   end

   // R7
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (STAGES == 2 && since_rst == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpad_pin.sv
module gpad_pin
   import gpad_pkg::*;
#(
   parameter bit HAS_KEEPER = 1'b1,
   parameter int FSEL_LSB   = 2,
   parameter int BIAS_LSB   = 0,
   parameter int DRV_LSB    = 6,
   parameter int OE_BIT     = 9,
   parameter int OUT_BIT    = 1,
   parameter int IN_BIT     = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_we,
   input  logic             data_we,
   input  logic [REG_W-1:0] wmask,
   input  logic [REG_W-1:0] wdata,
   input  logic             pad_in,
   output logic [REG_W-1:0] setup_img,
   output logic [REG_W-1:0] data_img,
   output logic             pad_out,
   output logic             pad_oe,
   output logic             pad_pu,
   output logic             pad_pd,
   output logic             pad_keep,
   output logic [2:0]       pad_drv,
   output logic [4:0]       pad_ma,
   output logic [2:0]       pad_fsel
);
   localparam logic [REG_W-1:0] BIAS_M = field_mask(BIAS_LSB, 2);
   localparam logic [REG_W-1:0] FSEL_M = field_mask(FSEL_LSB, 3);
   localparam logic [REG_W-1:0] DRV_M  = field_mask(DRV_LSB, 3);
   localparam logic [REG_W-1:0] OE_M   = field_mask(OE_BIT, 1);

   if (((BIAS_M & FSEL_M) | (BIAS_M & DRV_M) | (BIAS_M & OE_M) |
        (FSEL_M & DRV_M) | (FSEL_M & OE_M) | (DRV_M & OE_M)) != '0) begin : g_overlap
      $error("gpad_pin setup fields overlap");
   end
   if (FSEL_LSB < 0 || FSEL_LSB > REG_W-3) begin : g_fsel_range
      $error("gpad_pin function field outside register");
   end
   if (OUT_BIT == IN_BIT) begin : g_data_bits
      $error("gpad_pin data bits collide");
   end

   bias_e      bias_q;
   logic [2:0] fsel_q;
   logic [2:0] drv_q;
   logic       oe_q;
   logic       out_q;
   logic       in_sync;

   // merged write value; only the field slices below are consumed
   logic [REG_W-1:0] setup_next;
   always_comb begin
      setup_next = (setup_img & ~wmask) | (wdata & wmask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bias_q <= BIAS_DOWN;
         fsel_q <= '0;
         drv_q  <= '0;
         oe_q   <= 1'b0;
      end else if (setup_we) begin
         bias_q <= bias_e'(setup_next[BIAS_LSB +: 2]);
         fsel_q <= setup_next[FSEL_LSB +: 3];
         drv_q  <= setup_next[DRV_LSB +: 3];
         oe_q   <= setup_next[OE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      out_q <= 1'b0;
      else if (data_we && wmask[OUT_BIT]) out_q <= wdata[OUT_BIT];
   end

   gpad_sync #(.STAGES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   always_comb begin
      setup_img                   = '0;
      setup_img[BIAS_LSB +: 2]    = bias_q;
      setup_img[FSEL_LSB +: 3]    = fsel_q;
      setup_img[DRV_LSB +: 3]     = drv_q;
      setup_img[OE_BIT]           = oe_q;
      data_img                    = '0;
      data_img[OUT_BIT]           = out_q;
      data_img[IN_BIT]            = in_sync;
   end

   // bias decode: variant chosen at build time
   if (HAS_KEEPER) begin : g_keeper
      always_comb begin
         pad_pd   = (bias_q == BIAS_DOWN);
         pad_keep = (bias_q == BIAS_KEEP);
         pad_pu   = (bias_q == BIAS_UP);
      end
   end else begin : g_no_keeper
      always_comb begin
         pad_pd   = (bias_q == BIAS_DOWN);
         pad_keep = 1'b0;
         pad_pu   = (bias_q == BIAS_KEEP) || (bias_q == BIAS_UP);
      end
   end

   assign pad_oe   = oe_q;
   assign pad_out  = oe_q & out_q;
   assign pad_drv  = drv_q;
   assign pad_ma   = drive_to_ma(drv_q);
   assign pad_fsel = fsel_q;

   // R2
   bias_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pad_pu, pad_pd, pad_keep}));

   // R5
   oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_we && wmask[OE_BIT]) |=> (pad_oe == $past(wdata[OE_BIT])));

   // R5
   out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pad_oe) |-> (pad_out == 1'b0));

   // R4
   drive_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_ma >= 5'd2) && (pad_ma <= 5'd16) && !pad_ma[0]);
endmodule

// File: rtl/gpad_hold.sv
module gpad_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic strb0,
   input  logic bit0,
   output logic hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold <= 1'b1;
      else if (we && strb0) hold <= bit0;
   end

   // R11
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && strb0 && !bit0) |=> !hold);

   // R11
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && strb0) |=> $stable(hold));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpad_pkg::*;
#(
   parameter int          NUM_PINS   = 4,
   parameter int          ADDR_W     = 12,
   parameter bit          HAS_KEEPER = 1'b1,
   parameter int          FSEL_LSB   = 2,
   parameter logic [11:0] HOLD_OFFS  = 12'h820
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wdata,
   input  logic [REG_W/8-1:0]    wstrb,
   input  logic                  rd_en,
   output logic [REG_W-1:0]      rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_pu,
   output logic [NUM_PINS-1:0]   pad_pd,
   output logic [NUM_PINS-1:0]   pad_keep,
   output logic [3*NUM_PINS-1:0] pad_drv,
   output logic [5*NUM_PINS-1:0] pad_ma,
   output logic [3*NUM_PINS-1:0] pad_fsel,
   output logic                  power_hold
);
   localparam int STRB_W = REG_W / 8;
   localparam int WORD_W = ADDR_W - 2;
   localparam int SLOT_W = WORD_W - 1;
   localparam logic [WORD_W-1:0] HOLD_WORD = WORD_W'(HOLD_OFFS >> 2);

   if (NUM_PINS < 1 || NUM_PINS > (1 << SLOT_W)) begin : g_pins_range
      $error("gpio_pad_ctrl pin count does not fit address space");
   end
   if (ADDR_W < 12) begin : g_addr_range
      $error("gpio_pad_ctrl address too narrow for hold register");
   end
   if (HOLD_OFFS[1:0] != 2'b00) begin : g_hold_align
      $error("gpio_pad_ctrl hold offset must be word aligned");
   end

   // byte strobes to bit mask
   logic [REG_W-1:0] wmask;
   for (genvar b = 0; b < STRB_W; b++) begin : g_mask
      assign wmask[8*b +: 8] = {8{wstrb[b]}};
   end

   // decode
   logic [WORD_W-1:0] word;
   logic [SLOT_W-1:0] slot;
   logic              is_data;
   logic              pin_hit;
   logic              hold_hit;
   assign word     = addr[ADDR_W-1:2];
   assign slot     = word[WORD_W-1:1];
   assign is_data  = word[0];
   assign hold_hit = (word == HOLD_WORD);
   assign pin_hit  = ({1'b0, slot} < (SLOT_W+1)'(NUM_PINS)) && !hold_hit;

   logic [REG_W-1:0] setup_img [NUM_PINS];
   logic [REG_W-1:0] data_img  [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel;
      assign sel = pin_hit && (slot == SLOT_W'(p));

      gpad_pin #(
         .HAS_KEEPER (HAS_KEEPER),
         .FSEL_LSB   (FSEL_LSB)
      ) u_pin (
         .clk       (clk),
         .rst_n     (rst_n),
         .setup_we  (wr_en && sel && !is_data),
         .data_we   (wr_en && sel && is_data),
         .wmask     (wmask),
         .wdata     (wdata),
         .pad_in    (pad_in[p]),
         .setup_img (setup_img[p]),
         .data_img  (data_img[p]),
         .pad_out   (pad_out[p]),
         .pad_oe    (pad_oe[p]),
         .pad_pu    (pad_pu[p]),
         .pad_pd    (pad_pd[p]),
         .pad_keep  (pad_keep[p]),
         .pad_drv   (pad_drv[3*p +: 3]),
         .pad_ma    (pad_ma[5*p +: 5]),
         .pad_fsel  (pad_fsel[3*p +: 3])
      );
   end

   gpad_hold u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && hold_hit),
      .strb0 (wstrb[0]),
      .bit0  (wdata[0]),
      .hold  (power_hold)
   );

   // read mux, registered
   logic [REG_W-1:0] rd_sel;
   always_comb begin
      rd_sel = '0;
      if (hold_hit) begin
         rd_sel[0] = power_hold;
      end else if (pin_hit) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (slot == SLOT_W'(p)) rd_sel = is_data ? data_img[p] : setup_img[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_sel;
   end

   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !pin_hit && !hold_hit) |=> (rdata == '0));

   // R12
   rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_pad_ctrl_test.sv
module gpio_pad_ctrl_test;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata, rdata_nk;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_keep;
   logic [N-1:0] nk_out, nk_oe, nk_pu, nk_pd, nk_keep;
   logic [3*N-1:0] pad_drv, pad_fsel, nk_drv, nk_fsel;
   logic [5*N-1:0] pad_ma, nk_ma;
   logic        power_hold, nk_hold;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_pad_ctrl #(.NUM_PINS(N)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .wstrb(wstrb), .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .pad_keep(pad_keep), .pad_drv(pad_drv), .pad_ma(pad_ma),
      .pad_fsel(pad_fsel), .power_hold(power_hold)
   );

   gpio_pad_ctrl #(.NUM_PINS(N), .HAS_KEEPER(1'b0)) uut_nk (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .wstrb(wstrb), .rd_en(rd_en), .rdata(rdata_nk), .pad_in(pad_in),
      .pad_out(nk_out), .pad_oe(nk_oe), .pad_pu(nk_pu), .pad_pd(nk_pd),
      .pad_keep(nk_keep), .pad_drv(nk_drv), .pad_ma(nk_ma),
      .pad_fsel(nk_fsel), .power_hold(nk_hold)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      addr = a; wdata = d; wstrb = s; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wstrb = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      @(posedge clk);
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // {addr[79:68], strb[67:64], wdata[63:32], expected readback[31:0]}
   localparam int NV = 12;
   localparam logic [79:0] VEC [NV] = '{
      {12'h000, 4'hF, 32'hFFFF_FFFF, 32'h0000_03DF},  // R9 unimplemented bits read 0
      {12'h008, 4'hF, 32'h0000_0245, 32'h0000_0245},  // R6 R4 R5 pin1 setup
      {12'h010, 4'h1, 32'hFFFF_FFFF, 32'h0000_00DF},  // R9 low byte only, bit 8 kept
      {12'h010, 4'h2, 32'hFFFF_FF00, 32'h0000_03DF},  // R9 second byte only
      {12'h018, 4'hF, 32'h0000_0000, 32'h0000_0000},  // pin3 setup cleared
      {12'h00C, 4'hF, 32'h0000_0002, 32'h0000_0002},  // R8 pin1 out bit
      {12'h01C, 4'hF, 32'hFFFF_FFFF, 32'h0000_0002},  // R8 in bit read-only
      {12'h004, 4'hE, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 byte0 strobe off
      {12'h400, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
      {12'h820, 4'hF, 32'h0000_0000, 32'h0000_0000},  // R11 hold released
      {12'h820, 4'hF, 32'h0000_0001, 32'h0000_0001},  // R11 hold restored
      {12'h820, 4'h0, 32'h0000_0000, 32'h0000_0001}   // R11 no strobe, unchanged
   };

   initial begin
      #(4 * 100000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 power_hold", 32'(power_hold), 32'd1);
      check("R1 pad_pd", 32'(pad_pd), 32'hF);
      check("R1 pad_oe", 32'(pad_oe), 32'h0);
      check("R1 pad_ma pin0", 32'(pad_ma[4:0]), 32'd2);
      check("R1 pad_fsel", 32'(pad_fsel), 32'h0);
      bus_read(12'h000, r);
      check("R1 setup pin0", r, 32'h001);
      bus_read(12'h01C, r);
      check("R1 data pin3", r, 32'h000);

      // table walk: write then read back (R12 one-cycle read)
      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][79:68], VEC[i][63:32], VEC[i][67:64]);
         bus_read(VEC[i][79:68], r);
         check($sformatf("R12 vector %0d", i), r, VEC[i][31:0]);
      end

      // R10 unmapped write did not touch pin0
      bus_read(12'h000, r);
      check("R10 pin0 intact", r, 32'h3DF);

      // R5 output gating
      check("R5 pad_oe", 32'(pad_oe), 32'b0111);
      check("R5 pad_out", 32'(pad_out), 32'b0010);

      // R4 drive
      check("R4 pad_ma pin0", 32'(pad_ma[4:0]), 32'd16);
      check("R4 pad_ma pin1", 32'(pad_ma[9:5]), 32'd4);
      check("R4 pad_drv pin1", 32'(pad_drv[5:3]), 32'd1);

      // R6 function select
      check("R6 fsel pin0", 32'(pad_fsel[2:0]), 32'd7);
      check("R6 fsel pin1", 32'(pad_fsel[5:3]), 32'd1);

      // R2 / R3 bias decode
      bus_write(12'h010, 32'h0000_0002, 4'h1);
      check("R2 pad_keep", 32'(pad_keep), 32'b0100);
      check("R2 pad_pu", 32'(pad_pu), 32'b0001);
      check("R2 pad_pd", 32'(pad_pd), 32'b0010);
      check("R3 nk pad_pu", 32'(nk_pu), 32'b0101);
      check("R3 nk pad_keep", 32'(nk_keep), 32'b0000);

      // R7 synchroniser latency
      pad_in[2] = 1'b1;
      bus_read(12'h014, r);
      check("R7 first edge", r, 32'h0);
      bus_read(12'h014, r);
      check("R7 second edge", r, 32'h0);
      bus_read(12'h014, r);
      check("R7 third edge", r, 32'h1);

      // R11 hold line on the port
      bus_write(12'h820, 32'h0, 4'h1);
      check("R11 hold low", 32'(power_hold), 32'd0);
      bus_write(12'h820, 32'h1, 4'h1);
      check("R11 hold high", 32'(power_hold), 32'd1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule